// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and turns them into one interrupt request for a processor core. Each pin has its own 2-bit sense code. The code selects one of three triggers: a low level, a falling edge or a rising edge. Each pin also has a mask bit and a pending flag. Level-sensitive pins raise a request for as long as the pin stays low. Nothing is latched for them. Edge-sensitive pins latch a pending flag, and software clears that flag by writing a one to its bit. The block asserts a single combined request line and gives the index of the lowest-numbered active source.

The pins are split into two groups with different capture methods. On pins 0 to 3 the selected edge clocks a capture flop directly, so an edge is kept even while the system clock is stopped. Pins 4 to 7 are sampled through a two-flop synchronizer and compared with the previous sample, so they see edges only while the clock runs. The pin value alone drives triggering. If the pad is also driven from inside the chip, software can therefore raise its own interrupt.

A small register port with four addresses gives access to the two sense registers, the mask and the flags. Reads are combinational. Writes take effect at the clock edge where `wr_en` is high. Every pin and control is a plain level signal, and there is no handshake at the block's edge.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0 and `irq_idx` is 0. Sense code 0 means low-level mode.
- R2: Address 0 holds the sense codes of pins 0 to 3, and address 1 holds those of pins 4 to 7. Pin n uses bits [2(n mod 4)+1 : 2(n mod 4)]. Address 2 holds the mask, with bit n for pin n. Each of these reads back the value last written.
- R3: With sense code 00 (low level), pin n raises a request while it is low and drops it once it is high again. Its flag bit at address 3 reads 0 in this mode.
- R4: With sense code 10 (falling edge), a high-to-low change on pin n sets flag bit n at address 3. A low-to-high change does not set it.
- R5: With sense code 11 (rising edge), a low-to-high change on pin n sets flag bit n. A high-to-low change does not set it.
- R6: Sense code 01 is reserved. A pin with this code never reads a flag and never raises a request.
- R7: Writing address 3 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: `irq` is high only when `gie` is high and at least one pin has both a request (a level request or a set flag) and its mask bit set.
- R9: When several pins are active, `irq_idx` gives the lowest-numbered one.
- R10: On pins 0 to 3, a selected edge is captured even if it happens while the clock is stopped. On pins 4 to 7, a pulse that begins and ends while the clock is stopped is lost.
- R11: On pins 0 to 3, changing a pin's sense code from level to an edge mode can set its flag. For example, switching a high pin to rising mode does this. A later write-one clears that flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt enable |
| pin_i | input | 8 | External interrupt pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 sense low, 1 sense high, 2 mask, 3 flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |
| irq_idx | output | 3 | Index of the lowest-numbered active pin |

## Verification
The results appear at different clock edges after a stimulus.
- A level request on any pin reaches `irq` after the second clock edge, because it first passes through the synchronizer.
- On pins 0 to 3, a captured edge shows in the flags after two edges, and a write-one clear shows two edges after the write edge.
- On pins 4 to 7, an edge sets the flag at the third edge, and a clear takes effect at the write edge itself.

The bench waits four full cycles after every pin change, register write or clock restart. It then samples at mid-cycle, which covers the slowest of these paths with margin. A read only changes `addr` at mid-cycle and samples `rdata` one nanosecond later.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  localparam int NUM_PINS = 8;
  localparam int IDX_W    = $clog2(NUM_PINS);

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    ADR_SNS_LO = 2'd0,
    ADR_SNS_HI = 2'd1,
    ADR_MASK   = 2'd2,
    ADR_FLAG   = 2'd3
  } addr_e;
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eisc_line.sv
module eisc_line
  import eisc_pkg::*;
#(
  parameter bit ASYNC       = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin,
  input  sense_e sense,
  input  logic   clr,
  output logic   flag_o,
  output logic   lvl_o
);
  logic pin_s;
  logic flag_raw;

  eisc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  assign lvl_o = (sense == SNS_LOW) && !pin_s;

  generate
    if (ASYNC) begin : g_async
      // The selected edge itself clocks the capture flop.
      logic tclk;
      logic clr_q;
      logic arst;
      logic cap;

      assign tclk = sense[0] ? pin : ~pin;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr;
      end

      assign arst = ~rst_n | clr_q;

      always_ff @(posedge tclk or posedge arst) begin
        if (arst) cap <= 1'b0;
        else      cap <= 1'b1;
      end

      eisc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .d(cap), .q(flag_raw)
      );
    end else begin : g_sync
      logic prev;
      logic hit;
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= pin_s;
      end

      assign hit = sense[1] && (sense[0] ? (pin_s && !prev) : (!pin_s && prev));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
      end

      assign flag_raw = flag_q;

      // R4/R5/R6: a clocked flag only rises while an edge mode is selected
      assert_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(sense[1]));
    end
  endgenerate

  assign flag_o = sense[1] & flag_raw;
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
  import eisc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0] flags,
  output logic [NUM_PINS-1:0] rdata,
  output logic [2*NUM_PINS-1:0] sense_all,
  output logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] clr
);
  logic [NUM_PINS-1:0] sns_lo, sns_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sns_lo <= '0;
      sns_hi <= '0;
      mask   <= '0;
    end else if (wr_en) begin
      case (addr)
        ADR_SNS_LO: sns_lo <= wdata;
        ADR_SNS_HI: sns_hi <= wdata;
        ADR_MASK:   mask   <= wdata;
        default: ;
      endcase
    end
  end

  assign sense_all = {sns_hi, sns_lo};
  assign clr       = (wr_en && addr == ADR_FLAG) ? wdata : '0;

  always_comb begin
    case (addr)
      ADR_SNS_LO: rdata = sns_lo;
      ADR_SNS_HI: rdata = sns_hi;
      ADR_MASK:   rdata = mask;
      default:    rdata = flags;
    endcase
  end

  assert_mask_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_MASK) |=> mask == $past(wdata));
endmodule

// File: rtl/eisc_prio.sv
module eisc_prio
  import eisc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] req,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

  assert_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && (req & ~({NUM_PINS{1'b1}} << idx)) == '0));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eisc_pkg::*;
#(
  parameter int NUM_ASYNC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gie,
  input  logic [7:0]   pin_i,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  output logic         irq,
  output logic [2:0]   irq_idx
);
  logic [NUM_PINS-1:0]   flags, lvl, mask, clr, req;
  logic [2*NUM_PINS-1:0] sense_all;
  logic                  any;

  eisc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flags(flags), .rdata(rdata), .sense_all(sense_all), .mask(mask), .clr(clr)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_line
    eisc_line #(.ASYNC(n < NUM_ASYNC), .SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .pin(pin_i[n]),
      .sense(sense_e'(sense_all[2*n +: 2])), .clr(clr[n]),
      .flag_o(flags[n]), .lvl_o(lvl[n])
    );
  end

  assign req = (flags | lvl) & mask & {NUM_PINS{gie}};

  eisc_prio u_prio (
    .clk(clk), .rst_n(rst_n), .req(req), .any(any), .idx(irq_idx)
  );

  assign irq = any;

  assert_gie_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);
  assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask[irq_idx]);
endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       gie = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic [2:0] irq_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  ext_irq_sense u0 (
    .clk(clk), .rst_n(rst_n), .gie(gie), .pin_i(pin_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .irq_idx(irq_idx)
  );

  always begin
    #2;
    if (clk_run) clk = ~clk;
  end

  typedef struct packed {
    logic [2:0] line;
    logic [1:0] sns;
    logic       p0;
    logic       p1;
    logic       exp;
  } vec_t;

  // line, sense, start level, end level, expected flag
  localparam vec_t VECS [8] = '{
    '{3'd0, 2'b10, 1'b1, 1'b0, 1'b1},   // R4
    '{3'd0, 2'b11, 1'b1, 1'b0, 1'b0},   // R5
    '{3'd5, 2'b10, 1'b1, 1'b0, 1'b1},   // R4
    '{3'd5, 2'b11, 1'b0, 1'b1, 1'b1},   // R5
    '{3'd3, 2'b11, 1'b0, 1'b1, 1'b1},   // R5
    '{3'd7, 2'b01, 1'b1, 1'b0, 1'b0},   // R6
    '{3'd2, 2'b01, 1'b0, 1'b1, 1'b0},   // R6
    '{3'd6, 2'b10, 1'b0, 1'b1, 1'b0}    // R4
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_all();
    wait_cyc(4);
    wr(2'd3, 8'hFF);
    wait_cyc(4);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    rd(2'd0, v); check("R1 sense lo", v, 8'h00);
    rd(2'd1, v); check("R1 sense hi", v, 8'h00);
    rd(2'd2, v); check("R1 mask", v, 8'h00);
    rd(2'd3, v); check("R1 flags", v, 8'h00);
    check("R1 irq/idx", {4'd0, irq, irq_idx}, 8'h00);

    // R2 register readback
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h81);
    rd(2'd0, v); check("R2 sense lo", v, 8'hA5);
    rd(2'd1, v); check("R2 sense hi", v, 8'h3C);
    rd(2'd2, v); check("R2 mask", v, 8'h81);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    clear_all();

    // vector table: R4 R5 R6
    foreach (VECS[k]) begin
      pin_i = 8'hFF;
      pin_i[VECS[k].line] = VECS[k].p0;
      if (VECS[k].line < 3'd4) begin
        wr(2'd1, 8'h00);
        wr(2'd0, 8'({VECS[k].sns} << (2 * VECS[k].line[1:0])));
      end else begin
        wr(2'd0, 8'h00);
        wr(2'd1, 8'({VECS[k].sns} << (2 * VECS[k].line[1:0])));
      end
      clear_all();
      pin_i[VECS[k].line] = VECS[k].p1;
      wait_cyc(4);
      rd(2'd3, v);
      check($sformatf("R4/R5/R6 vector %0d flag", k), {7'd0, v[VECS[k].line]}, {7'd0, VECS[k].exp});
    end
    pin_i = 8'hFF;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    clear_all();

    // R3 level mode on pin 6, not latched
    gie = 1'b1;
    wr(2'd2, 8'h40);
    pin_i[6] = 1'b0;
    wait_cyc(4);
    check("R3 level irq", {4'd0, irq, irq_idx}, {4'd0, 1'b1, 3'd6});
    rd(2'd3, v); check("R3 level flag reads 0", v, 8'h00);
    pin_i[6] = 1'b1;
    wait_cyc(4);
    check("R3 level released", {7'd0, irq}, 8'h00);

    // R6 reserved code gives no request
    wr(2'd1, 8'h10);              // pin 6 code 01
    clear_all();
    pin_i[6] = 1'b0;
    wait_cyc(4);
    check("R6 reserved no irq", {7'd0, irq}, 8'h00);
    pin_i[6] = 1'b1;
    wr(2'd1, 8'h00);
    clear_all();

    // R9 priority, R8 gating: pins 2 and 5 falling
    wr(2'd0, 8'h20); wr(2'd1, 8'h08);
    clear_all();
    pin_i[2] = 1'b0; pin_i[5] = 1'b0;
    wait_cyc(4);
    wr(2'd2, 8'hFF);
    wait_cyc(1);
    check("R9 lowest index", {4'd0, irq, irq_idx}, {4'd0, 1'b1, 3'd2});
    wr(2'd2, 8'hFB);
    wait_cyc(1);
    check("R9 next index", {4'd0, irq, irq_idx}, {4'd0, 1'b1, 3'd5});
    gie = 1'b0;
    wait_cyc(1);
    check("R8 gie low", {7'd0, irq}, 8'h00);
    gie = 1'b1;
    wr(2'd2, 8'h00);
    wait_cyc(1);
    check("R8 mask low", {7'd0, irq}, 8'h00);

    // R7 write-one clears, write-zero keeps
    rd(2'd3, v); check("R7 flags before", v, 8'h24);
    wr(2'd3, 8'h04);
    wait_cyc(4);
    rd(2'd3, v); check("R7 selective clear", v, 8'h20);
    wr(2'd3, 8'h00);
    wait_cyc(4);
    rd(2'd3, v); check("R7 zero write keeps", v, 8'h20);
    pin_i = 8'hFF;

    // R10 clock stopped: pins 0 and 4 falling
    wr(2'd0, 8'h02); wr(2'd1, 8'h02);
    clear_all();
    @(negedge clk);
    clk_run = 1'b0;
    #10 pin_i[0] = 1'b0; pin_i[4] = 1'b0;
    #1  pin_i[0] = 1'b1; pin_i[4] = 1'b1;
    #10 clk_run = 1'b1;
    wait_cyc(4);
    rd(2'd3, v); check("R10 async kept / clocked lost", v & 8'h11, 8'h01);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    clear_all();

    // R11 mode switch on pin 1 (high) from level to rising
    pin_i[1] = 1'b0;
    wait_cyc(4);
    pin_i[1] = 1'b1;
    wait_cyc(4);
    rd(2'd3, v); check("R11 level mode flag 0", v, 8'h00);
    wr(2'd0, 8'h0C);
    wait_cyc(4);
    rd(2'd3, v); check("R11 switch sets flag", v & 8'h02, 8'h02);
    wr(2'd3, 8'h02);
    wait_cyc(4);
    rd(2'd3, v); check("R11 flag cleared", v, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule